// File: doc/BRIEF.md
# Printer Port Register Block

This block is the host-facing register set of a byte-wide printer port in plain compatibility mode. A host reaches it over a small register bus: a write strobe, a read strobe, a 3-bit offset and an 8-bit data word. Behind the bus sit five pieces of state:

- an output byte latch;
- an input byte latch that follows the peripheral data pins;
- a status byte whose bits change on their own as the host polls them;
- a control byte;
- an interrupt-pending flag.

On the peripheral side the block presents the byte that was last sent, together with a one-clock pulse that marks each send. An interrupt request line is driven as well.

A byte is sent when a control write raises the strobe bit from 0 to 1 while select and initialize are both high. The same kind of write also clears busy. The host then polls status to walk the acknowledge handshake. A poll that finds busy and strobe both low first drops acknowledge. The next such poll raises acknowledge and busy together, which ends the handshake and withdraws any pending interrupt.

Top module: `printer_port_regs`

## Requirements
- R1: After reset, status reads 0xD9, control reads 0x0C, and irq, byte_sent and pd_out are all 0.
- R2: Offset 0 is data, offset 1 is status and offset 2 is control. A control read returns the full byte last written to control.
- R3: A data read returns the input latch when control bit 5 (direction) is 1, and the output latch when it is 0. The input latch samples pd_in on every clock edge.
- R4: A control write with bit 2 (initialize) at 0 sets status to 0xD8.
- R5: A control write with bit 2 (initialize), bit 3 (select) and bit 0 (strobe) all at 1 clears status bit 7 (busy) and leaves the other status bits as they were.
- R6: If an R5 write finds the stored strobe bit at 0, the block sends the data latch: pd_out takes the byte and byte_sent is high in the cycle after the write. A second R5 write with the stored strobe already 1 sends nothing, and neither does a strobe write with select at 0.
- R7: A status read that finds busy at 0, stored strobe at 0 and status bit 6 (acknowledge) at 1 clears acknowledge.
- R8: A status read that finds busy, stored strobe and acknowledge all at 0 sets acknowledge and busy and clears interrupt-pending.
- R9: An R5 write whose written bit 4 (interrupt enable) is 1 sets interrupt-pending. irq equals interrupt-pending AND stored control bit 4.
- R10: Writes to status and to offsets 3 to 7 change nothing. Reads from offsets 3 to 7 return 0xFF.
- R11: byte_sent is never high for two clocks in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_ofs | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from offset |
| pd_in | input | 8 | Data pins driven by the peripheral |
| pd_out | output | 8 | Byte last sent to the peripheral |
| byte_sent | output | 1 | One-clock pulse per byte sent |
| irq | output | 1 | Interrupt request |

## Verification
Four strobe patterns are driven:

- a rising strobe with select high, which must send exactly one byte;
- the same strobe written again, which must send nothing;
- strobe with select low, which must neither send a byte nor touch busy;
- initialize low, which must overwrite status whatever its prior value.

The polling sequence is then run to separate the acknowledge-clear step from the acknowledge-and-busy step. It is also run with interrupts enabled, to show that the pending flag survives enable toggling and is cleared only by the final poll. Data reads are made with the direction bit both ways, so that the output latch and the input latch can be told apart.

// File: rtl/pp_pkg.sv
package pp_pkg;
  typedef logic [7:0] byte_t;

  localparam int unsigned OFS_DATA = 0;
  localparam int unsigned OFS_STAT = 1;
  localparam int unsigned OFS_CTRL = 2;

  // status bit positions
  localparam int unsigned SB_BUSY = 7;
  localparam int unsigned SB_ACK  = 6;
  localparam int unsigned SB_ERR  = 3;
  localparam int unsigned SB_ONL  = 4;
  localparam int unsigned SB_TMO  = 0;
  // control bit positions
  localparam int unsigned CB_DIR  = 5;
  localparam int unsigned CB_IEN  = 4;
  localparam int unsigned CB_SEL  = 3;
  localparam int unsigned CB_INIT = 2;
  localparam int unsigned CB_STB  = 0;

  localparam byte_t STAT_RST    = 8'hD9;
  localparam byte_t STAT_FORCED = 8'hD8;
  localparam byte_t STAT_MASK   = 8'hF9;
  localparam byte_t CTRL_RST    = 8'h0C;
  localparam byte_t UNUSED_RD   = 8'hFF;

  // written control value requests a strobe (init, select and strobe high)
  function automatic logic strobe_req(byte_t nc);
    return nc[CB_INIT] & nc[CB_SEL] & nc[CB_STB];
  endfunction

  // a byte leaves only when the stored strobe was low
  function automatic logic strobe_fire(byte_t oc, byte_t nc);
    return strobe_req(nc) & ~oc[CB_STB];
  endfunction

  function automatic byte_t stat_on_ctrl_wr(byte_t st, byte_t nc);
    byte_t r;
    r = st;
    if (!nc[CB_INIT]) r = STAT_FORCED;
    else if (nc[CB_SEL] && nc[CB_STB]) r[SB_BUSY] = 1'b0;
    return r;
  endfunction

  function automatic logic poll_active(byte_t st, byte_t c);
    return ~st[SB_BUSY] & ~c[CB_STB];
  endfunction

  function automatic byte_t stat_on_poll(byte_t st);
    byte_t r;
    r = st;
    if (st[SB_ACK]) r[SB_ACK] = 1'b0;
    else begin
      r[SB_ACK]  = 1'b1;
      r[SB_BUSY] = 1'b1;
    end
    return r;
  endfunction
endpackage

// File: rtl/pp_control.sv
module pp_control
  import pp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  data_wr,
  input  logic  ctrl_wr,
  input  byte_t wdata,
  output byte_t ctrl_q,
  output byte_t data_q,
  output byte_t pd_out,
  output logic  sent_q,
  output logic  fire_ev
);
  assign fire_ev = ctrl_wr & strobe_fire(ctrl_q, wdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      data_q <= '0;
      pd_out <= '0;
      sent_q <= 1'b0;
    end else begin
      sent_q <= fire_ev;
      if (data_wr) data_q <= wdata;
      if (ctrl_wr) ctrl_q <= wdata;
      if (fire_ev) pd_out <= data_q;
    end
  end

  assert_sent_one_clock_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sent_q |=> !sent_q);
  assert_stb_stored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sent_q |-> ctrl_q[CB_STB]);
endmodule

// File: rtl/pp_status.sv
module pp_status
  import pp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ctrl_wr,
  input  logic  stat_rd,
  input  byte_t wdata,
  input  byte_t ctrl_q,
  output byte_t status_q,
  output logic  pending_q
);
  logic poll_ev;
  assign poll_ev = stat_rd & poll_active(status_q, ctrl_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q  <= STAT_RST;
      pending_q <= 1'b0;
    end else if (ctrl_wr) begin
      status_q <= stat_on_ctrl_wr(status_q, wdata);
      if (wdata[CB_INIT] && strobe_req(wdata) && wdata[CB_IEN]) pending_q <= 1'b1;
    end else if (poll_ev) begin
      status_q <= stat_on_poll(status_q);
      if (!status_q[SB_ACK]) pending_q <= 1'b0;
    end
  end

  assert_init_forces_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !wdata[CB_INIT]) |=> status_q == STAT_FORCED);
  assert_busy_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wdata[CB_INIT] && wdata[CB_SEL] && wdata[CB_STB]) |=> !status_q[SB_BUSY]);
  assert_ack_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !status_q[SB_BUSY] && !ctrl_q[CB_STB] && status_q[SB_ACK]) |=> !status_q[SB_ACK]);
  assert_ack_busy_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !status_q[SB_BUSY] && !ctrl_q[CB_STB] && !status_q[SB_ACK])
    |=> (status_q[SB_ACK] && status_q[SB_BUSY] && !pending_q));
endmodule

// File: rtl/printer_port_regs.sv
module printer_port_regs
  import pp_pkg::*;
#(
  parameter int unsigned OFS_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [OFS_W-1:0] bus_ofs,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic [7:0]       pd_in,
  output logic [7:0]       pd_out,
  output logic             byte_sent,
  output logic             irq
);
  logic  data_wr, ctrl_wr, stat_rd, fire_ev, pending_q;
  byte_t ctrl_q, data_q, status_q, din_q;

  assign data_wr = bus_wr && (bus_ofs == OFS_W'(OFS_DATA));
  assign ctrl_wr = bus_wr && (bus_ofs == OFS_W'(OFS_CTRL));
  assign stat_rd = bus_rd && (bus_ofs == OFS_W'(OFS_STAT));

  always_ff @(posedge clk) begin
    if (!rst_n) din_q <= '0;
    else        din_q <= pd_in;
  end

  pp_control u_ctrl (
    .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .ctrl_wr(ctrl_wr),
    .wdata(bus_wdata), .ctrl_q(ctrl_q), .data_q(data_q), .pd_out(pd_out),
    .sent_q(byte_sent), .fire_ev(fire_ev)
  );

  pp_status u_stat (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .stat_rd(stat_rd),
    .wdata(bus_wdata), .ctrl_q(ctrl_q), .status_q(status_q), .pending_q(pending_q)
  );

  always_comb begin
    unique case (bus_ofs)
      OFS_W'(OFS_DATA): bus_rdata = ctrl_q[CB_DIR] ? din_q : data_q;
      OFS_W'(OFS_STAT): bus_rdata = status_q & STAT_MASK;
      OFS_W'(OFS_CTRL): bus_rdata = ctrl_q;
      default:          bus_rdata = UNUSED_RD;
    endcase
  end

  assign irq = pending_q & ctrl_q[CB_IEN];

  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ctrl_q[CB_IEN]);
  assert_send_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_sent |-> $past(bus_wr && bus_ofs == OFS_W'(OFS_CTRL) && bus_wdata[CB_STB]
                        && bus_wdata[CB_SEL] && bus_wdata[CB_INIT]));
  assert_unused_noctrl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_ofs > OFS_W'(OFS_CTRL) && !bus_rd) |=> $stable(ctrl_q));
endmodule

// File: tb/printer_port_regs_bench.sv
module printer_port_regs_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_ofs = '0;
  logic [7:0] bus_wdata = '0, pd_in = '0;
  logic [7:0] bus_rdata, pd_out;
  logic       byte_sent, irq;
  int checks = 0, errors = 0;
  logic [7:0] v;

  always #5 clk = ~clk;

  printer_port_regs u_printer_port_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_ofs(bus_ofs),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pd_in(pd_in), .pd_out(pd_out),
    .byte_sent(byte_sent), .irq(irq)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] o, logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_ofs = o; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] o, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_ofs = o;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic t_reset;
    rd(1, v); check("R1 status", v, 8'hD9);
    rd(2, v); check("R1 control", v, 8'h0C);
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 byte_sent", {7'd0, byte_sent}, 8'h00);
    check("R1 pd_out", pd_out, 8'h00);
  endtask

  task automatic t_data;
    wr(0, 8'hA5);
    rd(0, v); check("R3 output latch", v, 8'hA5);
    pd_in = 8'h3C;
    wr(2, 8'h2C);
    rd(0, v); check("R3 input latch", v, 8'h3C);
    rd(2, v); check("R2 control readback", v, 8'h2C);
    wr(2, 8'hCC);
    rd(2, v); check("R2 control full byte", v, 8'hCC);
    wr(2, 8'h0C);
  endtask

  task automatic t_strobe;
    wr(0, 8'h5A);
    wr(2, 8'h0D);
    check("R6 sent", {7'd0, byte_sent}, 8'h01);
    check("R6 pd_out", pd_out, 8'h5A);
    @(negedge clk);
    check("R11 one clock", {7'd0, byte_sent}, 8'h00);
    rd(1, v); check("R5 busy cleared", v, 8'h59);
    wr(2, 8'h0D);
    check("R6 repeat no send", {7'd0, byte_sent}, 8'h00);
    wr(2, 8'h0C);
  endtask

  task automatic t_poll;
    rd(1, v); check("R7 before", v, 8'h59);
    rd(1, v); check("R7 ack cleared", v, 8'h19);
    rd(1, v); check("R8 ack busy set", v, 8'hD9);
    rd(1, v); check("R8 stable", v, 8'hD9);
  endtask

  task automatic t_irq;
    wr(2, 8'h1D);
    check("R9 irq set", {7'd0, irq}, 8'h01);
    wr(2, 8'h0C);
    check("R9 irq gated", {7'd0, irq}, 8'h00);
    wr(2, 8'h1C);
    check("R9 pending kept", {7'd0, irq}, 8'h01);
    rd(1, v); check("R7 poll 1", v, 8'h59);
    check("R9 irq after poll 1", {7'd0, irq}, 8'h01);
    rd(1, v); check("R8 poll 2", v, 8'h19);
    check("R8 pending cleared", {7'd0, irq}, 8'h00);
    wr(2, 8'h0C);
  endtask

  task automatic t_init_select;
    wr(2, 8'h08);
    rd(1, v); check("R4 forced", v, 8'hD8);
    wr(2, 8'h0C);
    wr(2, 8'h05);
    check("R6 select low no send", {7'd0, byte_sent}, 8'h00);
    rd(1, v); check("R5 select low keeps busy", v, 8'hD8);
    wr(2, 8'h0C);
  endtask

  task automatic t_ignored;
    wr(1, 8'h00);
    rd(1, v); check("R10 status write ignored", v, 8'hD8);
    wr(5, 8'h00);
    rd(2, v); check("R10 unused write ctrl", v, 8'h0C);
    rd(0, v); check("R10 unused write data", v, 8'h5A);
    rd(6, v); check("R10 unused read", v, 8'hFF);
    rd(3, v); check("R10 unused read 3", v, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_data;
    t_strobe;
    t_poll;
    t_irq;
    t_init_select;
    t_ignored;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule